// File: doc/BRIEF.md
# Complementary Gate Driver with Unequal Non-Overlap Gaps

This block takes one pulse-width-modulated command and produces two gate commands for an active-clamp power stage. The main output follows the command pulse. The auxiliary output conducts while the main switch is off. At every hand-over there is a gap in which both outputs are off. The gap before the main output turns on lasts `DLY1` clock cycles. The gap before the auxiliary output turns on lasts `DLY2` cycles, and `DLY2` must exceed `DLY1`. Elaboration stops with an error when it does not.

The auxiliary output can be driven with either active level, so it can drive a switch that conducts on a high gate or on a low gate. The polarity is applied only at the final stage, so every off state of the auxiliary output shows the inactive level of the chosen polarity. Both outputs stay off while the block is disabled (startup not finished). They also stay off when the command stays low long enough to mean zero duty. During a fault the main output is forced off. The auxiliary output then runs on its own at a fixed period of `DLY1 + DLY2 + FLT_ON` cycles and is off for `DLY1 + DLY2` cycles of each period.

Top module: `cdt_driver`

## Requirements
- R1: While `rst_n` is low, or `enable` was low at the previous clock edge, `main_drv` is 0 and `aux_drv` equals `aux_invert` (auxiliary off). Command pulses have no effect during that time.
- R2: If `pwm_in` is first sampled high at edge k and stays high for W edges, `main_drv` is 1 after edges k+DLY1 through k+W-1. The main on time is therefore W-DLY1 cycles.
- R3: `main_drv` and the auxiliary active state are never 1 together. The auxiliary output is off for at least DLY1 cycles immediately before `main_drv` rises.
- R4: After a command pulse ends at edge k+W, the auxiliary output turns on after edge k+W+DLY2. This gives a DLY2-cycle gap after the main output turns off.
- R5: A command pulse of W <= DLY1 edges produces no main pulse. The auxiliary output still stays off during the pulse and for DLY2 cycles after it.
- R6: Zero duty: if the command stays low, the auxiliary output turns off after IDLE_LIM on-cycles and stays off until the next command pulse.
- R7: While `fault` is high (and `enable` is high), `main_drv` is 0 from the edge after `fault` is first sampled high. In the same cycle the auxiliary output starts a repeating cycle: off for DLY1+DLY2 cycles, then on for FLT_ON cycles.
- R8: `aux_drv` = auxiliary active state XOR `aux_invert`, with no added cycle. `aux_invert` has no effect on `main_drv`.
- R9: After `fault` falls, both outputs are off from the next edge. Normal operation resumes with the next command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | Command pulse; high requests main conduction |
| enable | input | 1 | Startup done; low forces both outputs off |
| fault | input | 1 | Fault flag; selects auxiliary-only oscillation |
| aux_invert | input | 1 | 0: auxiliary active high; 1: auxiliary active low |
| main_drv | output | 1 | Main switch gate command, active high |
| aux_drv | output | 1 | Auxiliary switch gate command, polarity per `aux_invert` |

## Verification
Random command pulses are applied, with widths on both sides of DLY1 and low times both shorter than DLY2 and longer than DLY2+IDLE_LIM. These separate correct on-time trimming from an off-by-one at either gap, and a pulse that restarts mid-gap from one that waits out the gap. Directed pulses of width exactly DLY1 and DLY1+1 show the edge between no main pulse and a one-cycle pulse. Fault runs with the command held high show whether the fault period, the gap inside it and the forced-off main output come from fault mode or from leftover command activity. Both polarities are used throughout, so a correct off level can be told apart from a correct active level.

// File: rtl/cdt_pkg.sv
// Package: shared state encoding and helpers for the complementary driver.
// Assumes: all delay counts are small positive integers.
package cdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // both off, waiting for a command pulse
        ST_GAP1 = 3'd1,   // both off, before main turns on
        ST_MAIN = 3'd2,   // main on
        ST_GAP2 = 3'd3,   // both off, before auxiliary turns on
        ST_AUX  = 3'd4,   // auxiliary on during main off time
        ST_FOFF = 3'd5,   // fault mode, auxiliary off part
        ST_FON  = 3'd6    // fault mode, auxiliary on part
    } cdt_state_e;

    // Larger of two integers, used to size counters.
    function automatic int cdt_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdt_timer.sv
// Module: saturating cycle counter, cleared when the sequencer changes state.
// Assumes: clr is asserted in the cycle before a new state begins.
module cdt_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    // Count cycles spent in the current state, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != CMAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cdt_fsm.sv
// Module: sequencer that orders main on, gaps, auxiliary on and fault mode.
// Assumes: DLY1 >= 1, DLY2 > DLY1, FLT_ON >= 1, IDLE_LIM >= 1, and the
// counter width CW holds every limit below.
module cdt_fsm
    import cdt_pkg::*;
#(
    parameter int DLY1     = 3,
    parameter int DLY2     = 5,
    parameter int FLT_ON   = 10,
    parameter int IDLE_LIM = 40,
    parameter int CW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm,
    input  logic          enable,
    input  logic          fault,
    input  logic [CW-1:0] cnt,
    output logic          clr,
    output logic          main_act,
    output logic          aux_act
);
    localparam logic [CW-1:0] LIM_G1   = CW'(DLY1 - 1);
    localparam logic [CW-1:0] LIM_G2   = CW'(DLY2 - 1);
    localparam logic [CW-1:0] LIM_IDLE = CW'(IDLE_LIM - 1);
    localparam logic [CW-1:0] LIM_FOFF = CW'(DLY1 + DLY2 - 1);
    localparam logic [CW-1:0] LIM_FON  = CW'(FLT_ON - 1);

    cdt_state_e st, nxt;
    logic       in_fault;

    assign in_fault = (st == ST_FOFF) || (st == ST_FON);

    // Choose the next state: disable first, then fault entry, then sequencing.
    always_comb begin
        nxt = st;
        if (!enable)
            nxt = ST_IDLE;
        else if (fault && !in_fault)
            nxt = ST_FOFF;
        else begin
            case (st)
                ST_IDLE: if (pwm) nxt = ST_GAP1;
                ST_GAP1: if (!pwm) nxt = ST_GAP2;
                         else if (cnt == LIM_G1) nxt = ST_MAIN;
                ST_MAIN: if (!pwm) nxt = ST_GAP2;
                ST_GAP2: if (pwm) nxt = ST_GAP1;
                         else if (cnt == LIM_G2) nxt = ST_AUX;
                ST_AUX:  if (pwm) nxt = ST_GAP1;
                         else if (cnt == LIM_IDLE) nxt = ST_IDLE;
                ST_FOFF: if (!fault) nxt = ST_IDLE;
                         else if (cnt == LIM_FOFF) nxt = ST_FON;
                ST_FON:  if (!fault) nxt = ST_IDLE;
                         else if (cnt == LIM_FON) nxt = ST_FOFF;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Hold the sequencer state; reset parks both switches off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // Restart the cycle counter on every state change.
    assign clr = (nxt != st);

    // Decode the logical (polarity-free) switch requests.
    assign main_act = (st == ST_MAIN);
    assign aux_act  = (st == ST_AUX) || (st == ST_FON);
endmodule

// File: rtl/cdt_polarity.sv
// Module: final output stage; applies the auxiliary polarity choice.
// Assumes: inputs are logical active-high requests.
module cdt_polarity (
    input  logic main_act,
    input  logic aux_act,
    input  logic aux_invert,
    output logic main_drv,
    output logic aux_drv
);
    // Main is always active high; auxiliary flips when inversion is selected.
    assign main_drv = main_act;
    assign aux_drv  = aux_act ^ aux_invert;
endmodule

// File: rtl/cdt_driver.sv
// Module: complementary main/auxiliary gate driver with unequal gaps.
// Assumes: pwm_in, enable and fault are synchronous to clk.
module cdt_driver
    import cdt_pkg::*;
#(
    parameter int DLY1     = 3,
    parameter int DLY2     = 5,
    parameter int FLT_ON   = 10,
    parameter int IDLE_LIM = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic enable,
    input  logic fault,
    input  logic aux_invert,
    output logic main_drv,
    output logic aux_drv
);
    localparam int MAXLIM = cdt_max(cdt_max(DLY1 + DLY2, FLT_ON), IDLE_LIM);
    localparam int CW     = $clog2(MAXLIM + 1);

    // Reject parameter sets that break the gap ordering.
    generate
        if (DLY2 <= DLY1) begin : g_bad_order
            $error("cdt_driver: DLY2 must be larger than DLY1");
        end
        if (DLY1 < 1 || FLT_ON < 1 || IDLE_LIM < 1) begin : g_bad_count
            $error("cdt_driver: delay counts must be at least 1");
        end
    endgenerate

    logic [CW-1:0] cnt;
    logic          clr;
    logic          main_act;
    logic          aux_act;

    cdt_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cnt   (cnt)
    );

    cdt_fsm #(
        .DLY1     (DLY1),
        .DLY2     (DLY2),
        .FLT_ON   (FLT_ON),
        .IDLE_LIM (IDLE_LIM),
        .CW       (CW)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm      (pwm_in),
        .enable   (enable),
        .fault    (fault),
        .cnt      (cnt),
        .clr      (clr),
        .main_act (main_act),
        .aux_act  (aux_act)
    );

    cdt_polarity out_i (
        .main_act   (main_act),
        .aux_act    (aux_act),
        .aux_invert (aux_invert),
        .main_drv   (main_drv),
        .aux_drv    (aux_drv)
    );
endmodule

// File: rtl/cdt_driver_chk.sv
// Module: checker for cdt_driver; watches the ports only.
// Assumes: bound to every cdt_driver instance by the bind below.
module cdt_driver_chk #(
    parameter int DLY1 = 3,
    parameter int DLY2 = 5
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fault,
    input logic aux_invert,
    input logic main_drv,
    input logic aux_drv
);
    localparam int RW = $clog2(DLY2 + 1);
    localparam logic [RW-1:0] RMAX = RW'(DLY2);

    logic          aux_on;
    logic [RW-1:0] aux_off_run;
    logic [RW-1:0] main_off_run;

    assign aux_on = (aux_drv != aux_invert);

    // Count consecutive cycles with each output off, saturating at DLY2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_off_run  <= '0;
            main_off_run <= '0;
        end else begin
            aux_off_run  <= aux_on   ? '0 : ((aux_off_run  == RMAX) ? RMAX : aux_off_run  + 1'b1);
            main_off_run <= main_drv ? '0 : ((main_off_run == RMAX) ? RMAX : main_off_run + 1'b1);
        end
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_drv && aux_on));

    assert_gap_before_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_drv) |-> (aux_off_run >= RW'(DLY1)));

    assert_gap_before_aux_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_on) |-> (main_off_run >= RW'(DLY2)));

    assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!main_drv && !aux_on));

    assert_fault_main_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !main_drv);
endmodule

bind cdt_driver cdt_driver_chk #(.DLY1(DLY1), .DLY2(DLY2)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fault      (fault),
    .aux_invert (aux_invert),
    .main_drv   (main_drv),
    .aux_drv    (aux_drv)
);

// File: tb/cdt_driver_tb_top.sv
`timescale 1ns/1ps
// Bench: random and directed command pulses, fault and disable scenarios.
module cdt_driver_tb_top;
    localparam int DLY1     = 3;
    localparam int DLY2     = 5;
    localparam int FLT_ON   = 10;
    localparam int IDLE_LIM = 40;
    localparam int FOFF     = DLY1 + DLY2;
    localparam int FPER     = FOFF + FLT_ON;

    logic clk = 1'b0;
    logic rst_n, pwm_in, enable, fault, aux_invert;
    logic main_drv, aux_drv;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #4 clk = ~clk;

    cdt_driver #(.DLY1(DLY1), .DLY2(DLY2), .FLT_ON(FLT_ON), .IDLE_LIM(IDLE_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
        .fault(fault), .aux_invert(aux_invert), .main_drv(main_drv), .aux_drv(aux_drv)
    );

    // Expected main level after edge k+i for a pulse of W edges.
    function automatic bit exp_main(input int i, input int w);
        return (i >= DLY1) && (i < w);
    endfunction

    // Expected auxiliary activity after edge k+i for a pulse of W edges.
    function automatic bit exp_aux(input int i, input int w);
        return (i >= w + DLY2) && (i < w + DLY2 + IDLE_LIM);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One pulse of W high edges then L low edges, checked every cycle.
    task automatic run_pulse(input int w, input int l, input bit inv);
        bit m_ok = 1, a_ok = 1, o_ok = 1;
        int m_act = 0, m_exp = 0, a_act = 0, a_exp = 0;
        aux_invert = inv;
        for (int i = 0; i < w + l; i++) begin
            pwm_in = (i < w);
            tick();
            if (m_ok && main_drv != exp_main(i, w)) begin
                m_ok = 0; m_act = main_drv; m_exp = exp_main(i, w);
            end
            if (a_ok && aux_drv != (exp_aux(i, w) ^ inv)) begin
                a_ok = 0; a_act = aux_drv; a_exp = exp_aux(i, w) ^ inv;
            end
            if (main_drv && (aux_drv != inv)) o_ok = 0;
        end
        check((w <= DLY1) ? "R5 main" : "R2 main", m_ok, m_act, m_exp);
        check((l > DLY2 + IDLE_LIM) ? "R6 aux" : (inv ? "R4 R8 aux" : "R4 aux"),
              a_ok, a_act, a_exp);
        check("R3 overlap", o_ok, 1, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        rst_n = 0; pwm_in = 0; enable = 1; fault = 0; aux_invert = 1;

        // R1: reset holds both off, even with a command present.
        pwm_in = 1;
        repeat (3) tick();
        check("R1 reset main", main_drv == 0, main_drv, 0);
        check("R1 reset aux", aux_drv == 1, aux_drv, 1);
        pwm_in = 0;
        rst_n = 1;
        tick();

        // R8: polarity applies at once with no added cycle.
        aux_invert = 0;
        #1;
        check("R8 aux idle level inv=0", aux_drv == 0, aux_drv, 0);
        aux_invert = 1;
        #1;
        check("R8 aux idle level inv=1", aux_drv == 1, aux_drv, 1);

        // Directed corner pulses: R5 boundary, shortest main pulse, zero duty R6.
        run_pulse(DLY1, 12, 0);
        run_pulse(DLY1 + 1, 3, 1);
        run_pulse(1, DLY2 + IDLE_LIM + 4, 0);
        run_pulse(8, DLY2 - 2, 1);
        run_pulse(8, DLY2 + 1, 0);

        // Random pulses with short and long low times.
        for (int n = 0; n < 60; n++) begin
            int w = 1 + int'($urandom % 12);
            int l = ($urandom % 3 == 0) ? (DLY2 + IDLE_LIM + 1 + int'($urandom % 6))
                                        : (1 + int'($urandom % 10));
            run_pulse(w, l, 1'($urandom % 2));
        end

        // R7: fault mode with the command held high.
        for (int r = 0; r < 2; r++) begin
            bit inv = 1'(r);
            bit m_ok = 1, a_ok = 1;
            run_pulse(9, 2, inv);
            fault = 1;
            for (int i = 0; i < 3 * FPER; i++) begin
                pwm_in = 1'($urandom % 2) | (i < 5);
                tick();
                if (main_drv != 0) m_ok = 0;
                if (aux_drv != (((i % FPER) >= FOFF) ^ inv)) a_ok = 0;
            end
            check("R7 fault main off", m_ok, 1, 0);
            check("R7 fault aux cycle", a_ok, 0, 1);
            // R9: release turns both off, then normal operation resumes.
            fault = 0; pwm_in = 0;
            tick();
            ok = (main_drv == 0) && (aux_drv == inv);
            check("R9 release off", ok, aux_drv, inv);
            run_pulse(7, 20, inv);
        end

        // R1: disable while the auxiliary is on; command pulses ignored.
        run_pulse(5, 12, 1);
        enable = 0; pwm_in = 1;
        ok = 1;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (main_drv != 0 || aux_drv != 1) ok = 0;
        end
        check("R1 disable off", ok, main_drv, 0);
        enable = 1; pwm_in = 0;
        tick();
        run_pulse(6, 15, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule